// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block takes the output of a floating-point datapath just before packing. That output is a sign, a biased exponent and a normalized significand that still carries three extra low bits. The block produces the final 32-bit single-precision word. The three extra bits are guard, round and sticky. Sticky is the OR of everything that was shifted out below the round position. A 2-bit mode input selects the rounding direction. The block adds the rounding increment and fixes the carry that can ripple out of the significand. It then decides whether the result has left the finite range and raises overflow and inexact flags.

The exponent input is one bit wider than the packed field. Values from 0 to 254 are ordinary biased exponents. The value 255 marks an operand that is already infinity or NaN: its fraction is copied through untouched. Values of 256 and above tell the stage that the upstream arithmetic has already exceeded the finite range. The result is registered once: one valid input cycle yields one valid output cycle on the next clock.

Top module: `fp_round_unit`

## Requirements
- R1: While reset is asserted, and until the first valid input after it, `out_valid`, `out_result`, `out_overflow` and `out_inexact` are all zero.
- R2: `out_valid` equals `in_valid` of the previous cycle. Result and flags change only on the clock after a cycle with `in_valid` high, and otherwise hold their value.
- R3: Mode 0 is round-to-nearest. The three low bits of `in_sig` (guard bit 2, round bit 1, sticky bit 0) are read as a fraction of one unit in the last place. The magnitude is incremented when that value is above 4 (binary 100) and truncated when it is below 4.
- R4: In mode 0, an exact tie (low bits binary 100) rounds to the neighbour whose fraction LSB is 0.
- R5: Mode 1 (toward zero) never increments. The fraction and exponent fields equal the input truncated.
- R6: Mode 2 (toward plus infinity) increments only a positive inexact value. Mode 3 (toward minus infinity) increments only a negative inexact value.
- R7: When the increment carries out of the 24-bit significand, the result fraction becomes zero and the exponent field grows by one.
- R8: When the exponent after rounding is 255 or more, `out_overflow` and `out_inexact` are 1. This also covers an input exponent of 256 or more. In that case, mode 0, mode 2 with a positive sign and mode 3 with a negative sign produce infinity: exponent field 255, fraction 0.
- R9: On overflow, mode 1, mode 2 with a negative sign and mode 3 with a positive sign produce the largest finite magnitude: exponent field 254, fraction all ones.
- R10: Outside overflow and pass-through, `out_inexact` is the OR of guard, round and sticky.
- R11: An input exponent of exactly 255 passes through as exponent field 255 with the input fraction unchanged, and both flags are 0.
- R12: `out_result` is packed with the sign at bit 31, the exponent field at bits 30:23 and the fraction at bits 22:0. `in_sig` carries the hidden bit at bit 26 and the fraction at bits 25:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 9 | Biased exponent, with headroom above 255 |
| in_sig | input | 27 | Hidden bit, 23 fraction bits, guard, round, sticky |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 to zero, 2 to +inf, 3 to -inf |
| out_valid | output | 1 | Result registered from the previous valid cycle |
| out_result | output | 32 | Packed single-precision word |
| out_overflow | output | 1 | Result left the finite range |
| out_inexact | output | 1 | Discarded bits were non-zero, or overflow |

## Verification
On every cycle, the assertions check the following:
- the valid pipeline follows its input one clock later;
- truncation in mode 1 keeps the input fraction;
- an overflow always carries the inexact flag and is encoded as either infinity or the largest finite word;
- pass-through operands are flagless;
- inexact matches the OR of the three low bits.

Only the bench scenarios can show the direction choices that depend on the data. These are the tie-to-even decision, the sign-dependent directed modes, the carry-driven renormalization and the choice between infinity and saturation. The bench compares each of them against its own integer-remainder model over directed ties and random operands.

// File: rtl/fp_rnd_pkg.sv
// Shared definitions for the rounding stage.
// Assumes the 2-bit mode code is fixed across the design and its bench.
package fp_rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_TO_POS    = 2'd2,
        RM_TO_NEG    = 2'd3
    } rmode_e;
endpackage

// File: rtl/fp_rnd_decide.sv
// Decides whether the kept significand must be incremented by one ULP.
// Assumes grs = {guard, round, sticky}, already OR-reduced upstream.
module fp_rnd_decide
    import fp_rnd_pkg::*;
(
    input  logic       sign,
    input  logic [1:0] mode,
    input  logic       lsb,
    input  logic [2:0] grs,
    output logic       bump,
    output logic       inexact
);
    logic   lost;
    rmode_e rm;

    // Any set bit below the kept LSB makes the result inexact.
    always_comb begin
        lost    = |grs;
        inexact = lost;
        rm      = rmode_e'(mode);
    end

    // Per-mode increment decision; a tie in nearest mode falls to the even LSB.
    always_comb begin
        unique case (rm)
            RM_NEAR_EVEN: bump = grs[2] & (grs[1] | grs[0] | lsb);
            RM_TO_ZERO:   bump = 1'b0;
            RM_TO_POS:    bump = lost & ~sign;
            RM_TO_NEG:    bump = lost & sign;
            default:      bump = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_rnd_incr.sv
// Adds the rounding increment and renormalizes on carry-out.
// Assumes a normalized significand (hidden bit set) on entry.
module fp_rnd_incr #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W:0]   exp_in,
    input  logic             bump,
    output logic [SIG_W-1:0] sig_out,
    output logic [EXP_W+1:0] exp_out
);
    logic [SIG_W:0] sum;
    logic           carry;

    // Increment, then shift right by one and bump the exponent if it carried.
    always_comb begin
        sum     = {1'b0, sig_in} + {{SIG_W{1'b0}}, bump};
        carry   = sum[SIG_W];
        sig_out = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
        exp_out = {1'b0, exp_in} + {{(EXP_W+1){1'b0}}, carry};
    end
endmodule

// File: rtl/fp_rnd_pack.sv
// Packs the rounded fields into a word and applies special-case selection:
// pass-through of all-ones exponents, and overflow to infinity or to the
// largest finite value depending on mode and sign.
module fp_rnd_pack
    import fp_rnd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    sign,
    input  logic [1:0]              mode,
    input  logic                    special,
    input  logic [FRAC_W-1:0]       raw_frac,
    input  logic [FRAC_W-1:0]       rnd_frac,
    input  logic [EXP_W+1:0]        rnd_exp,
    input  logic                    inexact_in,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    overflow,
    output logic                    inexact
);
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0] EXP_ONES = EXP_W'(EMAX);
    localparam logic [EXP_W-1:0] EXP_TOP  = EXP_W'(EMAX - 1);

    logic   to_inf;
    rmode_e rm;

    // Overflow goes to infinity only when rounding points away from zero.
    always_comb begin
        rm     = rmode_e'(mode);
        to_inf = (rm == RM_NEAR_EVEN) || (rm == RM_TO_POS && !sign) ||
                 (rm == RM_TO_NEG && sign);
    end

    // Select the packed word and flags.
    always_comb begin
        if (special) begin
            result   = {sign, EXP_ONES, raw_frac};
            overflow = 1'b0;
            inexact  = 1'b0;
        end else if (rnd_exp >= (EXP_W+2)'(EMAX)) begin
            result   = to_inf ? {sign, EXP_ONES, {FRAC_W{1'b0}}}
                              : {sign, EXP_TOP, {FRAC_W{1'b1}}};
            overflow = 1'b1;
            inexact  = 1'b1;
        end else begin
            result   = {sign, rnd_exp[EXP_W-1:0], rnd_frac};
            overflow = 1'b0;
            inexact  = inexact_in;
        end
    end
endmodule

// File: rtl/fp_round_unit.sv
// Single-stage rounding unit: decide, increment/renormalize, pack, register.
// Assumes in_sig holds {hidden, fraction, guard, round, sticky}; in_exp values
// above the all-ones field mean the range was already exceeded upstream.
module fp_round_unit #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sign,
    input  logic [EXP_W:0]             in_exp,
    input  logic [FRAC_W+3:0]          in_sig,
    input  logic [1:0]                 in_mode,
    output logic                       out_valid,
    output logic [EXP_W+FRAC_W:0]      out_result,
    output logic                       out_overflow,
    output logic                       out_inexact
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int EMAX   = (1 << EXP_W) - 1;

    logic              bump, inx_raw, special;
    logic [SIG_W-1:0]  sig_rnd;
    logic [EXP_W+1:0]  exp_rnd;
    logic [WORD_W-1:0] word_c;
    logic              ovf_c, inx_c;

    // Flag operands whose exponent is already the all-ones field.
    always_comb special = (in_exp == (EXP_W+1)'(EMAX));

    fp_rnd_decide u_decide (
        .sign    (in_sign),
        .mode    (in_mode),
        .lsb     (in_sig[3]),
        .grs     (in_sig[2:0]),
        .bump    (bump),
        .inexact (inx_raw)
    );

    fp_rnd_incr #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_incr (
        .sig_in  (in_sig[EXT_W-1:3]),
        .exp_in  (in_exp),
        .bump    (bump),
        .sig_out (sig_rnd),
        .exp_out (exp_rnd)
    );

    fp_rnd_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .sign       (in_sign),
        .mode       (in_mode),
        .special    (special),
        .raw_frac   (in_sig[EXT_W-2:3]),
        .rnd_frac   (sig_rnd[FRAC_W-1:0]),
        .rnd_exp    (exp_rnd),
        .inexact_in (inx_raw),
        .result     (word_c),
        .overflow   (ovf_c),
        .inexact    (inx_c)
    );

    // Output register: valid follows every cycle, data loads on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_overflow <= 1'b0;
            out_inexact  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result   <= word_c;
                out_overflow <= ovf_c;
                out_inexact  <= inx_c;
            end
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    a_r10_inexact_grs: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_exp) < (EXP_W+1)'(EMAX) && !out_overflow)
        |-> (out_inexact == (|$past(in_sig[2:0]))));

    a_r5_truncate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_mode) == 2'd1 && $past(in_exp) < (EXP_W+1)'(EMAX))
        |-> (!out_overflow &&
             out_result[FRAC_W-1:0] == $past(in_sig[EXT_W-2:3]) &&
             out_result[WORD_W-2:FRAC_W] == $past(in_exp[EXP_W-1:0])));

    a_r8_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_inexact);

    a_r9_ovf_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |->
        ((out_result[WORD_W-2:FRAC_W] == EXP_W'(EMAX) && out_result[FRAC_W-1:0] == '0) ||
         (out_result[WORD_W-2:FRAC_W] == EXP_W'(EMAX - 1) && (&out_result[FRAC_W-1:0]))));

    a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_exp) == (EXP_W+1)'(EMAX))
        |-> (!out_overflow && !out_inexact &&
             out_result[WORD_W-2:FRAC_W] == EXP_W'(EMAX) &&
             out_result[FRAC_W-1:0] == $past(in_sig[EXT_W-2:3])));
endmodule

// File: tb/fp_round_unit_tb.sv
// Bench: behavioural remainder-based reference, checked every clock.
module fp_round_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [8:0]  in_exp = '0;
    logic [26:0] in_sig = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_overflow, out_inexact;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    fp_round_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
        .out_valid(out_valid), .out_result(out_result),
        .out_overflow(out_overflow), .out_inexact(out_inexact)
    );

    // Reference: {overflow, inexact, word} from integer quotient and remainder.
    function automatic logic [33:0] ref_round(logic s, int e, logic [26:0] x, int m);
        int unsigned q   = x >> 3;
        int unsigned rem = x & 7;
        bit up = 0;
        bit toinf;
        if (e == 255) return {2'b00, s, 8'hFF, x[25:3]};
        case (m)
            0: up = (rem > 4) || (rem == 4 && (q % 2) == 1);
            1: up = 0;
            2: up = !s && rem != 0;
            default: up = s && rem != 0;
        endcase
        q = q + up;
        if (q == 32'h0100_0000) begin q = 32'h0080_0000; e = e + 1; end
        if (e >= 255) begin
            toinf = (m == 0) || (m == 2 && !s) || (m == 3 && s);
            return toinf ? {2'b11, s, 8'hFF, 23'h0} : {2'b11, s, 8'hFE, 23'h7FFFFF};
        end
        return {1'b0, rem != 0, s, e[7:0], q[22:0]};
    endfunction

    task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got ovf=%b inx=%b word=%h, expected ovf=%b inx=%b word=%h",
                     tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Drive one operand at a falling edge, check its result one clock later.
    task automatic run(string tag, logic s, int e, logic [22:0] frac, logic [2:0] grs, int m);
        logic [33:0] want;
        in_valid = 1'b1; in_sign = s; in_exp = 9'(e);
        in_sig = {1'b1, frac, grs}; in_mode = 2'(m);
        want = ref_round(s, e, {1'b1, frac, grs}, m);
        @(negedge clk);
        check(tag, {out_overflow, out_inexact, out_result}, want);
        check("R2 valid", {33'h0, out_valid}, 34'h1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [33:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset", {out_valid, out_overflow, out_inexact, out_result[30:0]}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {out_valid, out_overflow, out_inexact, out_result[30:0]}, 34'h0);

        run("R3 above half", 0, 100, 23'h000001, 3'b101, 0);
        run("R3 below half", 0, 100, 23'h000001, 3'b011, 0);
        run("R4 tie odd", 0, 100, 23'h000001, 3'b100, 0);
        run("R4 tie even", 1, 100, 23'h000002, 3'b100, 0);
        run("R5 to zero", 0, 100, 23'h12345F, 3'b111, 1);
        run("R6 pos up", 0, 90, 23'h000010, 3'b001, 2);
        run("R6 neg no-up", 1, 90, 23'h000010, 3'b001, 2);
        run("R6 neg down", 1, 90, 23'h000010, 3'b001, 3);
        run("R6 pos no-down", 0, 90, 23'h000010, 3'b001, 3);
        run("R10 exact", 0, 90, 23'h000010, 3'b000, 2);
        run("R7 carry", 0, 100, 23'h7FFFFF, 3'b110, 0);
        run("R7 carry neg", 1, 100, 23'h7FFFFF, 3'b001, 3);
        run("R8 carry to inf", 0, 254, 23'h7FFFFF, 3'b100, 0);
        run("R8 pre-overflow inf", 1, 300, 23'h0, 3'b000, 3);
        run("R9 sat to zero", 0, 300, 23'h0, 3'b010, 1);
        run("R9 sat neg up", 1, 300, 23'h0, 3'b010, 2);
        run("R9 sat pos down", 0, 256, 23'h0, 3'b000, 3);
        run("R11 pass", 1, 255, 23'h400000, 3'b111, 0);
        run("R12 packing", 0, 1, 23'h2AAAAA, 3'b000, 0);

        // R2: idle cycle keeps data and drops valid.
        held = {out_overflow, out_inexact, out_result};
        in_valid = 1'b0; in_exp = 9'd7; in_sig = '1;
        @(negedge clk);
        check("R2 hold", {out_overflow, out_inexact, out_result}, held);
        check("R2 valid low", {33'h0, out_valid}, 34'h0);

        for (int i = 0; i < 3000; i++) begin
            int m = $urandom_range(0, 3);
            int e = ($urandom_range(0, 7) == 0) ? 254 : $urandom_range(1, 254);
            logic [22:0] f = ($urandom_range(0, 5) == 0) ? 23'h7FFFFF : 23'($urandom);
            logic [2:0] g = 3'($urandom);
            run(m == 0 ? "R3 random" : (m == 1 ? "R5 random" : "R6 random"),
                1'($urandom), e, f, g, m);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule